// File: doc/BRIEF.md
# Multi-Digit Packed Decimal Adder

This block adds two packed decimal operands of `DIGITS` digits each, plus a single carry-in bit. Each operand holds one decimal digit per 4-bit nibble. Every digit position has a 4-bit binary adder whose 5-bit result goes to a decimal correction stage. The correction stage finds sums that fall outside the decimal range, brings them back into range and produces a decimal carry. That carry ripples into the next more-significant digit.

The caller presents both operands and the carry-in, then pulses `start` for one cycle. On that clock edge the block registers the packed decimal sum, the final decimal carry and a flag that marks any illegal operand digit. The registered outputs hold until the next `start`. `result_valid` is high for exactly the one cycle that follows the capturing edge.

Top module: `bcd_multi_adder`

## Requirements
- R1: For each digit, the binary sum is the operand nibbles plus the incoming carry. When that sum is 9 or less, the output nibble is the binary sum and the digit passes no carry.
- R2: When a digit's 5-bit binary sum S4..S0 meets S4 | (S3 & S2) | (S3 & S1), meaning a value of 10 or more, the output nibble is the low 4 bits of (sum + 6) and the digit's decimal carry is 1. For example, 5 + 5 gives nibble 0 with a carry.
- R3: The decimal carry of digit i is the carry-in of digit i+1. `carry_in` feeds digit 0.
- R4: `carry_out` is the decimal carry of the most significant digit. For example, 9999 + 0001 gives sum 0000 with `carry_out` = 1.
- R5: `bad_digit` is 1 when any nibble of either operand is 1010 to 1111. The sum is still formed by the R1/R2 rule, so FFFF + FFFF with carry-in 1 gives 5555 with a carry.
- R6: `result_valid` is 1 in the cycle after a cycle in which `start` was 1, and 0 otherwise.
- R7: When `start` is 0, changes to the operands or `carry_in` leave `sum_out`, `carry_out` and `bad_digit` unchanged.
- R8: While `rst_n` is low, all outputs are 0.
- R9: Digit 0, the least significant digit, is bits [3:0] of each operand and of `sum_out`. Digit i is bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture request for the current operands |
| op_a | input | 4*DIGITS | First packed decimal operand |
| op_b | input | 4*DIGITS | Second packed decimal operand |
| carry_in | input | 1 | Carry into digit 0 |
| sum_out | output | 4*DIGITS | Registered packed decimal sum |
| carry_out | output | 1 | Registered decimal carry out of the top digit |
| bad_digit | output | 1 | Registered flag for an illegal operand nibble |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The directed cases cover these corners:
- A digit sum of exactly 10. A correction term that misses S3·S1 would leave the output at 1010 with no carry.
- All-nines operands with and without carry-in. A break in the ripple would drop the carry partway up the chain, which would show up as a wrong high digit or a lost `carry_out`.
- Illegal nibbles, including an all-F pair. A wrong flag or an output that does not follow the correction rule would show up in `bad_digit` or `sum_out`.

Operand changes while `start` is low must leave the outputs unchanged. A design that latched its inputs without `start` would show them as changed.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  localparam int NIB = 4;

  // raw binary sum of two nibbles and a carry, 5 bits wide
  function automatic logic [NIB:0] nib_raw_sum(input logic [NIB-1:0] a,
                                               input logic [NIB-1:0] b,
                                               input logic           ci);
    return {1'b0, a} + {1'b0, b} + {{NIB{1'b0}}, ci};
  endfunction

  // decimal correction term from the 5-bit raw sum
  function automatic logic nib_needs_fix(input logic [NIB:0] s);
    return s[4] | (s[3] & s[2]) | (s[3] & s[1]);
  endfunction

  // corrected nibble: low bits of raw+6 when fixing, raw otherwise
  function automatic logic [NIB-1:0] nib_fixed(input logic [NIB:0] s,
                                               input logic       fix);
    logic [NIB:0] adj;
    adj = s + (fix ? 5'd6 : 5'd0);
    return adj[NIB-1:0];
  endfunction

  // nibble holds a code above nine
  function automatic logic nib_illegal(input logic [NIB-1:0] n);
    return n[3] & (n[2] | n[1]);
  endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_add_pkg::*;
(
  input  logic [NIB-1:0] a_nib,
  input  logic [NIB-1:0] b_nib,
  input  logic           c_in,
  output logic [NIB-1:0] d_out,
  output logic           c_out,
  output logic           fix_hit
);

  logic [NIB:0] raw_sum;
  logic         fix_term;

  always_comb begin
    raw_sum  = nib_raw_sum(a_nib, b_nib, c_in);
    fix_term = nib_needs_fix(raw_sum);
    d_out    = nib_fixed(raw_sum, fix_term);
    c_out    = fix_term;
    fix_hit  = fix_term;
  end

endmodule

// File: rtl/bcd_nibble_guard.sv
module bcd_nibble_guard
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = NIB * DIGITS
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic         any_bad
);

  logic [DIGITS-1:0] bad_a;
  logic [DIGITS-1:0] bad_b;

  for (genvar g = 0; g < DIGITS; g++) begin : g_nib
    assign bad_a[g] = nib_illegal(word_a[g*NIB +: NIB]);
    assign bad_b[g] = nib_illegal(word_b[g*NIB +: NIB]);
  end

  assign any_bad = |{bad_a, bad_b};

endmodule

// File: rtl/bcd_ripple_chain.sv
module bcd_ripple_chain
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = NIB * DIGITS
) (
  input  logic [W-1:0]      add_a,
  input  logic [W-1:0]      add_b,
  input  logic              add_ci,
  output logic [W-1:0]      add_sum,
  output logic              add_co,
  output logic [DIGITS-1:0] fix_vec
);

  logic [DIGITS:0] carry_link;

  assign carry_link[0] = add_ci;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_digit_cell u_cell (
      .a_nib  (add_a[g*NIB +: NIB]),
      .b_nib  (add_b[g*NIB +: NIB]),
      .c_in   (carry_link[g]),
      .d_out  (add_sum[g*NIB +: NIB]),
      .c_out  (carry_link[g+1]),
      .fix_hit(fix_vec[g])
    );
  end

  assign add_co = carry_link[DIGITS];

endmodule

// File: rtl/bcd_multi_adder.sv
module bcd_multi_adder
  import bcd_add_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = NIB * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         bad_digit,
  output logic         result_valid
);

  logic [W-1:0]      comb_sum;
  logic              comb_co;
  logic              comb_bad;
  logic [DIGITS-1:0] fix_vec;

  bcd_ripple_chain #(.DIGITS(DIGITS)) u_chain (
    .add_a  (op_a),
    .add_b  (op_b),
    .add_ci (carry_in),
    .add_sum(comb_sum),
    .add_co (comb_co),
    .fix_vec(fix_vec)
  );

  bcd_nibble_guard #(.DIGITS(DIGITS)) u_guard (
    .word_a (op_a),
    .word_b (op_b),
    .any_bad(comb_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out      <= '0;
      carry_out    <= 1'b0;
      bad_digit    <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= start;
      if (start) begin
        sum_out   <= comb_sum;
        carry_out <= comb_co;
        bad_digit <= comb_bad;
      end
    end
  end

endmodule

// File: rtl/bcd_multi_adder_chk.sv
module bcd_multi_adder_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [W-1:0]      op_a,
  input logic [W-1:0]      op_b,
  input logic              carry_in,
  input logic [W-1:0]      sum_out,
  input logic              carry_out,
  input logic              bad_digit,
  input logic              result_valid,
  input logic [DIGITS-1:0] fix_vec
);

  function automatic logic has_bad(input logic [W-1:0] x);
    logic r;
    r = 1'b0;
    for (int i = 0; i < DIGITS; i++)
      if (x[i*4 +: 4] > 4'd9) r = 1'b1;
    return r;
  endfunction

  function automatic logic sum_legal(input logic [W-1:0] x);
    return !has_bad(x);
  endfunction

  assert_valid_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_valid);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sum_out) && $stable(carry_out) && $stable(bad_digit)));

  assert_flag_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (has_bad(op_a) || has_bad(op_b))) |=> bad_digit);

  assert_top_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fix_vec[DIGITS-1]) |=> carry_out);

  assert_legal_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !bad_digit) |-> sum_legal(sum_out));

endmodule

bind bcd_multi_adder bcd_multi_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .op_a        (op_a),
  .op_b        (op_b),
  .carry_in    (carry_in),
  .sum_out     (sum_out),
  .carry_out   (carry_out),
  .bad_digit   (bad_digit),
  .result_valid(result_valid),
  .fix_vec     (fix_vec)
);

// File: tb/bcd_multi_adder_test.sv
module bcd_multi_adder_test;

  localparam int DIGITS = 4;
  localparam int W = 4 * DIGITS;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum_out;
  logic         carry_out;
  logic         bad_digit;
  logic         result_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bcd_multi_adder #(.DIGITS(DIGITS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out),
    .bad_digit(bad_digit), .result_valid(result_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // decimal model: digit by digit with integer arithmetic
  function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic ci);
    logic [W-1:0] s;
    int c, raw;
    c = int'(ci);
    s = '0;
    for (int i = 0; i < DIGITS; i++) begin
      raw = int'(a[i*4 +: 4]) + int'(b[i*4 +: 4]) + c;
      if (raw >= 10) begin
        s[i*4 +: 4] = 4'((raw + 6) % 16);
        c = 1;
      end else begin
        s[i*4 +: 4] = 4'(raw);
        c = 0;
      end
    end
    return {c[0], s};
  endfunction

  function automatic logic ref_bad(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int i = 0; i < DIGITS; i++)
      if (a[i*4 +: 4] > 9 || b[i*4 +: 4] > 9) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[i*4 +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, check the cycle after capture
  task automatic run_op(input string req, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic ci);
    logic [W:0] exp;
    logic [W-1:0] held;
    exp = ref_add(a, b, ci);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, {1'b0, result_valid, bad_digit, carry_out, sum_out},
               {1'b0, 1'b1, ref_bad(a, b), exp[W], exp[W-1:0]});
    held = sum_out;
    // R7: disturb the inputs without start
    op_a = ~a; op_b = rand_bcd(); carry_in = ~ci;
    @(negedge clk);
    check("R6/R7 idle", {1'b0, result_valid, bad_digit, carry_out, sum_out},
                        {1'b0, 1'b0, ref_bad(a, b), exp[W], held});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2);
    @(negedge clk);
    check("R8 reset", {1'b0, result_valid, bad_digit, carry_out, sum_out}, '0);
    rst_n = 1'b1;
    run_op("R1 small", 16'h1234, 16'h4321, 1'b0);
    check("R9 digit0", {3'b0, sum_out}, {3'b0, 16'h5555});
    run_op("R2 ten", 16'h0005, 16'h0005, 1'b0);
    check("R9 digit0 carry", {3'b0, sum_out}, {3'b0, 16'h0010});
    run_op("R2 nineteen", 16'h0009, 16'h0009, 1'b1);
    run_op("R3 ripple", 16'h0999, 16'h0001, 1'b0);
    run_op("R3 carry_in", 16'h0009, 16'h0000, 1'b1);
    run_op("R4 top carry", 16'h9999, 16'h0001, 1'b0);
    run_op("R4 max", 16'h9999, 16'h9999, 1'b1);
    run_op("R1 zero", 16'h0000, 16'h0000, 1'b0);
    run_op("R5 one bad", 16'h00A0, 16'h0001, 1'b0);
    run_op("R5 all F", 16'hFFFF, 16'hFFFF, 1'b1);
    run_op("R5 bad b", 16'h1234, 16'hC000, 1'b0);
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] a, b;
      a = rand_bcd();
      b = rand_bcd();
      if (n % 10 == 0) a[(n % DIGITS)*4 +: 4] = 4'(10 + $urandom % 6);
      run_op("R1 R2 R3 R5 random", a, b, 1'($urandom));
    end
    // R8: asynchronous reset clears captured state
    run_op("R4 before reset", 16'h9999, 16'h9999, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R8 mid reset", {1'b0, result_valid, bad_digit, carry_out, sum_out}, '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule